// File: doc/BRIEF.md
# DDS Register Write Sequencer

This block drives a parallel-bus direct digital synthesiser whose pins are reached only through four byte-wide latches. It never touches the DDS pins itself. Every action becomes a latch-write operation (latch select, value, mask) that it offers on a valid/ready master port to a separate latch writer. One DDS register write takes four latch operations. The data byte is placed on the data latch first. The write strobe on the control latch is then raised with the address, dropped with the address held, and raised again.

An init request starts a fixed power-up script. The script zeroes all four latches, pulses the DDS reset bit while the strobe is idle, and then programs seven registers: the comparator power-down, the PLL bypass, the output-control setup and the two amplitude multipliers. The `init_done` flag is low from reset until the script has finished. Host register writes are accepted only while the block is idle and `init_done` is high.

Both stream interfaces follow valid/ready rules. A request transfers on a clock edge where valid and ready are both high. The host write port is ready only when the block is idle, initialised, and no init request is present in that cycle. The latch port keeps its operation stable while `lw_ready` is low, so back-pressure from the latch writer stalls the sequence without losing or reordering any step.

Top module: `dds_regwr_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `lw_valid`, `init_done` and `wr_ready` are all 0.
- R2: A host write of address A and data D issues exactly four latch operations, each with mask 0xFF, in this order: data latch (select 2) = D; control latch (select 3) = 0x40|A; control latch = A; control latch = 0x40. Bit 6 of the control latch is the active-low write strobe and bit 7 is the DDS reset, which stays 0 here.
- R3: Only the low 6 bits of `wr_addr` are used. Higher address bits do not change any latch value.
- R4: A pulse on `init_req` while idle issues 34 latch operations, all with mask 0xFF. The first four zero the latches in the order band (1), control (3), data (2), external (0). Next come control = 0xC0 and then control = 0x40. Last are the register writes (each as in R2) 0x1D=0x10, 0x1E=0x20, 0x20=0x60, 0x21=0x0F, 0x22=0xFF, 0x23=0x0F, 0x24=0xFF. These last four carry the default amplitude 4095, high byte before low byte.
- R5: `wr_ready` stays 0 while `init_done` is 0, so no write is taken before or during initialisation.
- R6: If `init_req` and `wr_valid` are both high in an idle cycle, the init script starts and the write waits. The write is then taken after `init_done` rises.
- R7: While `lw_valid` is high and `lw_ready` is low, the offered operation stays unchanged and the sequence does not advance.
- R8: `init_req` has no effect while a host write or the init script is in progress.
- R9: `wr_ready` is 0 from the cycle after a write is taken until the cycle after its fourth latch operation is accepted.
- R10: `init_done` rises in the cycle after the 34th init operation is accepted, and it falls when a new init starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_req | input | 1 | Start the power-up script (sampled when idle) |
| init_done | output | 1 | Power-up script has completed |
| wr_valid | input | 1 | Host register write request valid |
| wr_ready | output | 1 | Block can take a host write this cycle |
| wr_addr | input | 8 | DDS register address; only bits 5:0 used |
| wr_data | input | 8 | DDS register data byte |
| lw_valid | output | 1 | Latch operation offered |
| lw_ready | input | 1 | Latch writer takes the operation |
| lw_sel | output | 2 | Latch select: 0 external, 1 band, 2 DDS data, 3 DDS control |
| lw_value | output | 8 | Value to merge into the latch |
| lw_mask | output | 8 | Bits of the latch to replace |

## Verification
The init request and a host write request can arrive in the same idle cycle. The bench provokes this by raising `init_req` and `wr_valid` on the same edge after a completed initialisation. It then checks that `wr_ready` is low, that `init_done` drops, and that the next latch operations are the full 34-step script rather than the write. The same write, still held valid, must then be taken and emitted as its four-step sequence once `init_done` is back high.

// File: rtl/dds_seq_pkg.sv
package dds_seq_pkg;

  typedef enum logic [1:0] {
    LT_EXT  = 2'd0,
    LT_BAND = 2'd1,
    LT_DATA = 2'd2,
    LT_CTRL = 2'd3
  } latch_sel_e;

  localparam int unsigned REG_ADDR_W  = 6;
  localparam int unsigned STROBE_BIT  = 6;
  localparam int unsigned RESET_BIT   = 7;
  localparam int unsigned WR_STEPS    = 4;
  localparam int unsigned STEP_W      = $clog2(WR_STEPS);

  typedef struct packed {
    latch_sel_e  sel;
    logic [7:0]  value;
    logic [7:0]  mask;
  } latch_op_t;

  typedef struct packed {
    logic                  is_reg;
    latch_op_t             raw;
    logic [REG_ADDR_W-1:0] addr;
    logic [7:0]            data;
  } script_item_t;

endpackage

// File: rtl/dds_wr_expand.sv
module dds_wr_expand
  import dds_seq_pkg::*;
(
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [7:0]            data,
  input  logic [STEP_W-1:0]     step,
  output latch_op_t             op
);
  localparam logic [7:0] STROBE_HI = 8'(1) << STROBE_BIT;

  logic [7:0] addr_byte;
  assign addr_byte = {{(8-REG_ADDR_W){1'b0}}, addr};

  always_comb begin
    op.mask = 8'hFF;
    unique case (step)
      2'd0: begin op.sel = LT_DATA; op.value = data;                  end
      2'd1: begin op.sel = LT_CTRL; op.value = addr_byte | STROBE_HI; end
      2'd2: begin op.sel = LT_CTRL; op.value = addr_byte;             end
      default: begin op.sel = LT_CTRL; op.value = STROBE_HI;          end
    endcase
  end
endmodule

// File: rtl/dds_init_script.sv
module dds_init_script
  import dds_seq_pkg::*;
#(
  parameter int unsigned AMP_MULT = 4095,
  parameter int unsigned IDX_W    = 4
)(
  input  logic [IDX_W-1:0] idx,
  output script_item_t     item
);
  localparam logic [15:0] AMP_WORD   = 16'(AMP_MULT);
  localparam logic [7:0]  STROBE_HI  = 8'(1) << STROBE_BIT;
  localparam logic [7:0]  RESET_HI   = 8'(1) << RESET_BIT;
  localparam int unsigned N_CLEAR    = 4;
  localparam int unsigned N_RAW      = N_CLEAR + 2;
  localparam int unsigned N_SETUP    = 3;
  localparam int unsigned N_AMP_CH   = 2;

  latch_sel_e clear_sel [N_CLEAR];
  assign clear_sel[0] = LT_BAND;
  assign clear_sel[1] = LT_CTRL;
  assign clear_sel[2] = LT_DATA;
  assign clear_sel[3] = LT_EXT;

  logic [REG_ADDR_W-1:0] reg_addr [N_SETUP + 2*N_AMP_CH];
  logic [7:0]            reg_data [N_SETUP + 2*N_AMP_CH];

  assign reg_addr[0] = 6'h1D; assign reg_data[0] = 8'h10;
  assign reg_addr[1] = 6'h1E; assign reg_data[1] = 8'h20;
  assign reg_addr[2] = 6'h20; assign reg_data[2] = 8'h60;

  for (genvar ch = 0; ch < N_AMP_CH; ch++) begin : g_amp
    assign reg_addr[N_SETUP + 2*ch]     = 6'(6'h21 + 2*ch);
    assign reg_data[N_SETUP + 2*ch]     = AMP_WORD[15:8];
    assign reg_addr[N_SETUP + 2*ch + 1] = 6'(6'h22 + 2*ch);
    assign reg_data[N_SETUP + 2*ch + 1] = AMP_WORD[7:0];
  end

  always_comb begin
    item            = '0;
    item.raw.sel    = LT_EXT;
    item.raw.mask   = 8'hFF;
    if (int'(idx) < N_CLEAR) begin
      item.raw.sel   = clear_sel[idx[1:0]];
      item.raw.value = 8'h00;
    end else if (int'(idx) == N_CLEAR) begin
      item.raw.sel   = LT_CTRL;
      item.raw.value = RESET_HI | STROBE_HI;
    end else if (int'(idx) == N_CLEAR + 1) begin
      item.raw.sel   = LT_CTRL;
      item.raw.value = STROBE_HI;
    end else if (int'(idx) < N_RAW + N_SETUP + 2*N_AMP_CH) begin
      item.is_reg = 1'b1;
      item.addr   = reg_addr[3'(int'(idx) - N_RAW)];
      item.data   = reg_data[3'(int'(idx) - N_RAW)];
    end
  end
endmodule

// File: rtl/dds_regwr_seq.sv
module dds_regwr_seq
  import dds_seq_pkg::*;
#(
  parameter int unsigned ADDR_IN_W = 8,
  parameter int unsigned AMP_MULT  = 4095
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init_req,
  output logic                 init_done,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [ADDR_IN_W-1:0] wr_addr,
  input  logic [7:0]           wr_data,
  output logic                 lw_valid,
  input  logic                 lw_ready,
  output logic [1:0]           lw_sel,
  output logic [7:0]           lw_value,
  output logic [7:0]           lw_mask
);
  localparam int unsigned N_ITEMS = 13;
  localparam int unsigned IDX_W   = $clog2(N_ITEMS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(WR_STEPS - 1);

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_HOST} state_e;

  state_e                state_q;
  logic [IDX_W-1:0]      idx_q;
  logic [STEP_W-1:0]     step_q;
  logic [REG_ADDR_W-1:0] host_addr_q;
  logic [7:0]            host_data_q;

  logic unused_addr_hi;
  assign unused_addr_hi = ^wr_addr[ADDR_IN_W-1:REG_ADDR_W];

  script_item_t item;
  latch_op_t    exp_op, cur_op;
  logic [REG_ADDR_W-1:0] exp_addr;
  logic [7:0]            exp_data;

  dds_init_script #(.AMP_MULT(AMP_MULT), .IDX_W(IDX_W)) u_script (
    .idx  (idx_q),
    .item (item)
  );

  assign exp_addr = (state_q == S_INIT) ? item.addr : host_addr_q;
  assign exp_data = (state_q == S_INIT) ? item.data : host_data_q;

  dds_wr_expand u_expand (
    .addr (exp_addr),
    .data (exp_data),
    .step (step_q),
    .op   (exp_op)
  );

  assign cur_op   = (state_q == S_INIT && !item.is_reg) ? item.raw : exp_op;
  assign lw_valid = (state_q != S_IDLE);
  assign lw_sel   = cur_op.sel;
  assign lw_value = cur_op.value;
  assign lw_mask  = cur_op.mask;

  logic hs, item_last_step, last_item;
  assign hs             = lw_valid && lw_ready;
  assign item_last_step = (state_q == S_INIT && !item.is_reg) || (step_q == LAST_STEP);
  assign last_item      = (idx_q == IDX_W'(N_ITEMS - 1));
  assign wr_ready       = (state_q == S_IDLE) && init_done && !init_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      init_done   <= 1'b0;
      idx_q       <= '0;
      step_q      <= '0;
      host_addr_q <= '0;
      host_data_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (init_req) begin
            state_q   <= S_INIT;
            init_done <= 1'b0;
            idx_q     <= '0;
            step_q    <= '0;
          end else if (wr_valid && wr_ready) begin
            state_q     <= S_HOST;
            host_addr_q <= wr_addr[REG_ADDR_W-1:0];
            host_data_q <= wr_data;
            step_q      <= '0;
          end
        end
        S_INIT: begin
          if (hs) begin
            if (item_last_step) begin
              step_q <= '0;
              if (last_item) begin
                state_q   <= S_IDLE;
                init_done <= 1'b1;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end else begin
              step_q <= step_q + 1'b1;
            end
          end
        end
        default: begin
          if (hs) begin
            if (step_q == LAST_STEP) begin
              state_q <= S_IDLE;
              step_q  <= '0;
            end else begin
              step_q <= step_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R7: offered operation is frozen under back-pressure
  p_hold_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lw_valid && !lw_ready |=> lw_valid && $stable({lw_sel, lw_value, lw_mask}));

  // R5: no host write can be taken before initialisation completes
  p_ready_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !wr_ready);

  // R6: a simultaneous init request wins over a write request
  p_init_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init_req && wr_valid && !lw_valid |=> lw_valid && !init_done && lw_sel == 2'(LT_BAND));

  // R10: init_done only rises right after an accepted control-latch operation
  p_done_after_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(lw_valid && lw_ready && lw_sel == 2'(LT_CTRL)));

  // R9: host port is closed while a sequence is on the latch port
  p_busy_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lw_valid |-> !wr_ready);

  // R2: every latch operation replaces the whole byte
  p_full_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lw_valid |-> lw_mask == 8'hFF);

  // R8: an init request during a host write does not clear init_done
  p_busy_ignores_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lw_valid && init_done && init_req |=> init_done);

endmodule

// File: tb/dds_regwr_seq_bench.sv
`timescale 1ns/1ps
module dds_regwr_seq_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, init_req, init_done, wr_valid, wr_ready, lw_valid, lw_ready;
  logic [7:0] wr_addr, wr_data, lw_value, lw_mask;
  logic [1:0] lw_sel;

  dds_regwr_seq u_dds_regwr_seq (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_done(init_done),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .lw_valid(lw_valid), .lw_ready(lw_ready), .lw_sel(lw_sel),
    .lw_value(lw_value), .lw_mask(lw_mask)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic get_op(string req, logic [1:0] sel, logic [7:0] val);
    int w = 0;
    while (!lw_valid && w < 50) begin @(negedge clk); w++; end
    chk(req, "lw_valid", {7'd0, lw_valid}, 8'd1);
    chk(req, "lw_sel", {6'd0, lw_sel}, {6'd0, sel});
    chk(req, "lw_value", lw_value, val);
    chk(req, "lw_mask", lw_mask, 8'hFF);
    @(negedge clk);
  endtask

  // expected host write ops (R2): data, ctrl 0x40|a, ctrl a, ctrl 0x40
  task automatic expect_write(string req, logic [5:0] a, logic [7:0] d);
    get_op(req, 2'd2, d);
    get_op(req, 2'd3, 8'h40 | {2'b00, a});
    get_op(req, 2'd3, {2'b00, a});
    get_op(req, 2'd3, 8'h40);
  endtask

  task automatic expect_init();
    get_op("R4", 2'd1, 8'h00);
    get_op("R4", 2'd3, 8'h00);
    get_op("R4", 2'd2, 8'h00);
    get_op("R4", 2'd0, 8'h00);
    get_op("R4", 2'd3, 8'hC0);
    get_op("R4", 2'd3, 8'h40);
    expect_write("R4", 6'h1D, 8'h10);
    expect_write("R4", 6'h1E, 8'h20);
    expect_write("R4", 6'h20, 8'h60);
    expect_write("R4", 6'h21, 8'h0F);
    expect_write("R4", 6'h22, 8'hFF);
    expect_write("R4", 6'h23, 8'h0F);
    expect_write("R4", 6'h24, 8'hFF);
  endtask

  task automatic take_write(logic [7:0] a, logic [7:0] d);
    int w = 0;
    while (!wr_ready && w < 50) begin @(negedge clk); w++; end
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // {wr_addr, wr_data}
  localparam logic [15:0] VEC [6] = '{16'h05A5, 16'hC53C, 16'h3F00,
                                      16'hFFFF, 16'h4081, 16'h007E};

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; init_req = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    lw_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "lw_valid in reset", {7'd0, lw_valid}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "lw_valid", {7'd0, lw_valid}, 8'd0);
    chk("R1", "init_done", {7'd0, init_done}, 8'd0);
    chk("R1", "wr_ready", {7'd0, wr_ready}, 8'd0);

    // R5: writes held off before any init
    wr_valid = 1'b1; wr_addr = 8'h11; wr_data = 8'h22;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R5", "wr_ready before init", {7'd0, wr_ready}, 8'd0);
      chk("R5", "lw_valid before init", {7'd0, lw_valid}, 8'd0);
    end
    wr_valid = 1'b0;

    // R4/R10: full init script
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    chk("R10", "init_done low while running", {7'd0, init_done}, 8'd0);
    chk("R5", "wr_ready during init", {7'd0, wr_ready}, 8'd0);
    expect_init();
    chk("R10", "init_done after script", {7'd0, init_done}, 8'd1);
    chk("R4", "no extra op", {7'd0, lw_valid}, 8'd0);

    // R2/R3: table of host writes
    for (int v = 0; v < 6; v++) begin
      take_write(VEC[v][15:8], VEC[v][7:0]);
      chk("R9", "wr_ready busy", {7'd0, wr_ready}, 8'd0);
      expect_write((VEC[v][15:14] != 2'b00) ? "R3" : "R2", VEC[v][13:8], VEC[v][7:0]);
      chk("R9", "wr_ready after write", {7'd0, wr_ready}, 8'd1);
    end

    // R7: back-pressure holds the operation
    take_write(8'h2A, 8'h5C);
    lw_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7", "held sel", {6'd0, lw_sel}, 8'd2);
      chk("R7", "held value", lw_value, 8'h5C);
    end
    lw_ready = 1'b1;
    get_op("R7", 2'd2, 8'h5C);
    lw_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7", "held step1", lw_value, 8'h6A);
    lw_ready = 1'b1;
    get_op("R7", 2'd3, 8'h6A);
    get_op("R7", 2'd3, 8'h2A);
    get_op("R7", 2'd3, 8'h40);

    // R8: init request during a host write is ignored
    take_write(8'h07, 8'h99);
    init_req = 1'b1;
    get_op("R8", 2'd2, 8'h99);
    init_req = 1'b0;
    chk("R9", "wr_ready mid write", {7'd0, wr_ready}, 8'd0);
    get_op("R8", 2'd3, 8'h47);
    get_op("R8", 2'd3, 8'h07);
    get_op("R8", 2'd3, 8'h40);
    for (int i = 0; i < 3; i++) begin
      chk("R8", "no init started", {7'd0, lw_valid}, 8'd0);
      chk("R8", "init_done kept", {7'd0, init_done}, 8'd1);
      @(negedge clk);
    end

    // R6: init and write in the same idle cycle
    init_req = 1'b1; wr_valid = 1'b1; wr_addr = 8'h33; wr_data = 8'hE1;
    @(negedge clk);
    init_req = 1'b0;
    chk("R6", "wr_ready during collision", {7'd0, wr_ready}, 8'd0);
    chk("R6", "init_done dropped", {7'd0, init_done}, 8'd0);
    chk("R6", "first op is init", {6'd0, lw_sel}, 8'd1);
    expect_init();
    chk("R6", "init_done back", {7'd0, init_done}, 8'd1);
    chk("R6", "write ready after init", {7'd0, wr_ready}, 8'd1);
    @(negedge clk);
    wr_valid = 1'b0;
    expect_write("R6", 6'h33, 8'hE1);

    finish_run();
  end
endmodule